// File: doc/BRIEF.md
# ARINC 429 Serial Word Receiver

This block assembles ARINC 429 words from a line interface that has already been decoded. For each bit time, the line interface reports exactly one of three symbols: a one, a zero, or a null (the line is idle between words). A single-cycle bit tick marks the clock cycle in which that symbol is valid. The receiver shifts data symbols into a word register, counts them, and uses runs of null symbols to find word boundaries.

A word is accepted only in this situation:
- a long enough idle gap came before it,
- exactly the word length of data bits arrived, and
- a null followed the last bit.

When a word is accepted, it is delivered with a one-cycle valid strobe. Before delivery, its most significant bit is replaced by a parity status flag. A sequence that breaks off early, runs long, or contains an illegal symbol combination is dropped, and the receiver raises a one-cycle error pulse instead.

Top module: `a429_word_rx`

## Requirements
- R1: After reset, `word_valid` and `seq_error` are 0 and `word_out` is all zeros. The receiver is not armed, so data symbols that arrive before a full idle gap are ignored and raise no error.
- R2: On a tick, the line state is decoded as follows. `line_one` alone is a 1 bit, `line_zero` alone is a 0 bit, and `line_null` alone is a null. Any other combination is illegal. An illegal symbol aborts a word in progress with an error pulse and clears the idle-gap count.
- R3: The first data bit of a word lands in `word_out[0]`, and the k-th data bit lands in `word_out[k-1]`.
- R4: A word of WORD_BITS data bits followed by a null tick produces `word_valid` high for exactly one cycle. That cycle is the one right after the clock edge that sampled the null.
- R5: Bit WORD_BITS-1 of a delivered word is 0 when the count of ones over all received bits, including the last bit, is odd. It is 1 when that count is even.
- R6: A data symbol starts a new word only if at least GAP_MIN consecutive null ticks came just before it. An earlier data symbol is ignored with no error, and it restarts the gap count.
- R7: A null that arrives after 1 to WORD_BITS-1 data bits gives a one-cycle `seq_error` pulse and no `word_valid`. That null counts as the first tick of the next gap.
- R8: A data symbol that arrives after WORD_BITS data bits, instead of a null, gives a one-cycle `seq_error` pulse and no `word_valid`. A full gap is then required again.
- R9: `word_out` changes only in a cycle where `word_valid` is high. `word_valid` and `seq_error` are never high together.
- R10: When `bit_tick` is low, the line inputs have no effect, and both strobes stay low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe marking a valid bit-time symbol |
| line_one | input | 1 | Line reports a logic one |
| line_zero | input | 1 | Line reports a logic zero |
| line_null | input | 1 | Line reports an idle (null) bit time |
| word_out | output | WORD_BITS | Last delivered word, with the parity flag in its top bit |
| word_valid | output | 1 | One-cycle strobe: a new word is on `word_out` |
| seq_error | output | 1 | One-cycle strobe: a malformed sequence was dropped |

## Verification
The bench targets these corner cases:
- **Gap threshold.** The gap is cut one null short of the threshold and also met exactly. A receiver that arms too early would raise a false error at the next null.
- **Length boundary.** Words are broken off at the bit before the last, and words are run one bit past the end. An off-by-one bit counter would deliver a truncated word, or miss the overrun error.
- **Parity flag.** Words with odd and even ones counts check the sense of the flag. A design that inverts the sense, or leaves out the final received bit, flips `word_out[31]`.
- **Bit order and line states.** Fixed bit patterns check the LSB-first bit order. Illegal symbol combinations are injected, both inside words and while `bit_tick` is low. These expose a reversed shift, or a decoder that trusts a single line.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;

  typedef enum logic [1:0] {
    RX_WAIT = 2'd0,
    RX_BITS = 2'd1,
    RX_FULL = 2'd2
  } rx_state_e;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_ONE  = 2'd1,
    SYM_NULL = 2'd2,
    SYM_BAD  = 2'd3
  } line_sym_e;

  function automatic line_sym_e decode_line(input logic one, input logic zero, input logic nul);
    case ({one, zero, nul})
      3'b100:  return SYM_ONE;
      3'b010:  return SYM_ZERO;
      3'b001:  return SYM_NULL;
      default: return SYM_BAD;
    endcase
  endfunction

endpackage

// File: rtl/a429_gap_tracker.sv
module a429_gap_tracker #(
  parameter int GAP_MIN = 4,
  localparam int GW = $clog2(GAP_MIN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic is_null,
  output logic armed
);

  localparam logic [GW-1:0] GAP_TOP = GW'(GAP_MIN);

  logic [GW-1:0] run_q;

  // consecutive null ticks, saturating at the arming threshold
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (tick) begin
      if (!is_null)            run_q <= '0;
      else if (run_q != GAP_TOP) run_q <= run_q + 1'b1;
    end
  end

  assign armed = (run_q == GAP_TOP);

endmodule

// File: rtl/a429_bit_shifter.sv
module a429_bit_shifter #(
  parameter int WORD_BITS = 32,
  localparam int CW = $clog2(WORD_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic                 first,
  input  logic                 bit_in,
  output logic [WORD_BITS-1:0] sh,
  output logic [CW-1:0]        cnt
);

  // LSB-first: new bits enter at the top and move down
  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      cnt <= '0;
    end else if (shift_en) begin
      sh  <= {bit_in, sh[WORD_BITS-1:1]};
      cnt <= first ? CW'(1) : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/a429_parity_stamp.sv
module a429_parity_stamp #(
  parameter int WORD_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 deliver,
  input  logic                 abort,
  input  logic [WORD_BITS-1:0] raw,
  output logic [WORD_BITS-1:0] word_q,
  output logic                 vld_q,
  output logic                 err_q
);

  logic even_ones;
  assign even_ones = ~(^raw);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      vld_q <= deliver;
      err_q <= abort;
      if (deliver) word_q <= {even_ones, raw[WORD_BITS-2:0]};
    end
  end

endmodule

// File: rtl/a429_word_rx.sv
module a429_word_rx
  import a429_rx_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int GAP_MIN   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_tick,
  input  logic                 line_one,
  input  logic                 line_zero,
  input  logic                 line_null,
  output logic [WORD_BITS-1:0] word_out,
  output logic                 word_valid,
  output logic                 seq_error
);

  localparam int CW = $clog2(WORD_BITS + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(WORD_BITS - 1);

  line_sym_e           sym;
  rx_state_e           st_q, st_nx;
  logic                armed, shift_en, first, deliver, abort;
  logic [WORD_BITS-1:0] sh;
  logic [CW-1:0]        cnt;

  assign sym = decode_line(line_one, line_zero, line_null);

  a429_gap_tracker #(.GAP_MIN(GAP_MIN)) u_gap (
    .clk(clk), .rst(rst), .tick(bit_tick),
    .is_null(sym == SYM_NULL), .armed(armed)
  );

  a429_bit_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .first(first),
    .bit_in(sym == SYM_ONE), .sh(sh), .cnt(cnt)
  );

  a429_parity_stamp #(.WORD_BITS(WORD_BITS)) u_stamp (
    .clk(clk), .rst(rst), .deliver(deliver), .abort(abort), .raw(sh),
    .word_q(word_out), .vld_q(word_valid), .err_q(seq_error)
  );

  always_comb begin
    st_nx    = st_q;
    shift_en = 1'b0;
    first    = 1'b0;
    deliver  = 1'b0;
    abort    = 1'b0;
    if (bit_tick) begin
      case (sym)
        SYM_NULL: begin
          if (st_q == RX_BITS) abort = 1'b1;
          if (st_q == RX_FULL) deliver = 1'b1;
          st_nx = RX_WAIT;
        end
        SYM_ZERO, SYM_ONE: begin
          case (st_q)
            RX_WAIT: if (armed) begin
              shift_en = 1'b1;
              first    = 1'b1;
              st_nx    = (WORD_BITS == 1) ? RX_FULL : RX_BITS;
            end
            RX_BITS: begin
              shift_en = 1'b1;
              if (cnt == LAST_IDX) st_nx = RX_FULL;
            end
            default: begin
              abort = 1'b1;
              st_nx = RX_WAIT;
            end
          endcase
        end
        default: begin
          if (st_q != RX_WAIT) abort = 1'b1;
          st_nx = RX_WAIT;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= RX_WAIT;
    else     st_q <= st_nx;
  end

endmodule

// File: rtl/a429_word_rx_chk.sv
module a429_word_rx_chk #(
  parameter int WORD_BITS = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bit_tick,
  input logic [WORD_BITS-1:0] word_out,
  input logic                 word_valid,
  input logic                 seq_error
);

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(word_valid && seq_error));

  p_word_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !word_valid |-> $stable(word_out));

  p_valid_after_tick_r4: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(bit_tick));

  p_valid_single_r4: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  p_error_after_tick_r7: assert property (@(posedge clk) disable iff (rst)
    seq_error |-> $past(bit_tick));

  p_quiet_without_tick_r10: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> !(word_valid || seq_error));

endmodule

bind a429_word_rx a429_word_rx_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk(clk), .rst(rst), .bit_tick(bit_tick), .word_out(word_out),
  .word_valid(word_valid), .seq_error(seq_error)
);

// File: tb/sim_a429_word_rx.sv
module sim_a429_word_rx;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 32;
  localparam int GAPN = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic rst, bit_tick, line_one, line_zero, line_null;
  logic [NB-1:0] word_out;
  logic word_valid, seq_error;

  a429_word_rx u0 (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .line_one(line_one),
    .line_zero(line_zero), .line_null(line_null), .word_out(word_out),
    .word_valid(word_valid), .seq_error(seq_error)
  );

  int total = 0, bad = 0;
  // reference model state: 0 waiting, 1 in word, 2 word full
  int m_st = 0, m_gap = 0, m_cnt = 0;
  logic [NB-1:0] m_sh = '0, m_last = '0;

  task automatic check(input bit ok, input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sym: 0 zero, 1 one, 2 null, 3 illegal combination
  task automatic drive(input int sym, input bit tk);
    bit_tick = tk;
    case (sym)
      0: {line_one, line_zero, line_null} = 3'b010;
      1: {line_one, line_zero, line_null} = 3'b100;
      2: {line_one, line_zero, line_null} = 3'b001;
      default: case ($urandom % 4)
        0: {line_one, line_zero, line_null} = 3'b000;
        1: {line_one, line_zero, line_null} = 3'b110;
        2: {line_one, line_zero, line_null} = 3'b101;
        default: {line_one, line_zero, line_null} = 3'b111;
      endcase
    endcase
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      drive($urandom % 4, 1'b0);
      @(posedge clk); @(negedge clk);
      check(!word_valid && !seq_error, "R10 strobes without tick", {word_valid, seq_error}, 0);
    end
  endtask

  task automatic tick(input int sym, input string req);
    logic ev, ee;
    logic [NB-1:0] ew;
    ev = 0; ee = 0; ew = m_last;
    if (sym == 2) begin
      if (m_st == 1) ee = 1;
      if (m_st == 2) begin ev = 1; ew = {~(^m_sh), m_sh[NB-2:0]}; end
      m_st = 0;
      if (m_gap < GAPN) m_gap++;
    end else if (sym < 2) begin
      if (m_st == 0) begin
        if (m_gap >= GAPN) begin m_sh = {sym[0], m_sh[NB-1:1]}; m_cnt = 1; m_st = 1; end
      end else if (m_st == 1) begin
        m_sh = {sym[0], m_sh[NB-1:1]}; m_cnt++;
        if (m_cnt == NB) m_st = 2;
      end else begin
        ee = 1; m_st = 0;
      end
      m_gap = 0;
    end else begin
      if (m_st != 0) ee = 1;
      m_st = 0; m_gap = 0;
    end
    drive(sym, 1'b1);
    @(posedge clk); @(negedge clk);
    bit_tick = 1'b0;
    check(word_valid == ev, {req, " valid"}, word_valid, ev);
    check(seq_error == ee, {req, " error"}, seq_error, ee);
    check(word_out == ew, {req, " word (R9 hold)"}, word_out, ew);
    m_last = ew;
    idle($urandom % 2);
  endtask

  task automatic gap(input int n, input string req);
    for (int i = 0; i < n; i++) tick(2, req);
  endtask

  task automatic send_word(input logic [NB-1:0] d, input string req);
    for (int i = 0; i < NB; i++) tick(d[i] ? 1 : 0, req);
    tick(2, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1;
    drive(2, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(word_valid == 0, "R1 reset valid", word_valid, 0);
    check(seq_error == 0, "R1 reset error", seq_error, 0);
    check(word_out == 0, "R1 reset word", word_out, 0);

    // R1/R6: data before any gap is ignored
    for (int i = 0; i < 5; i++) tick(i % 2, "R1 unarmed data");
    gap(GAPN - 1, "R6 short gap");
    tick(1, "R6 data after short gap");
    gap(GAPN, "R6 gap ok");
    send_word(32'h0000_0001, "R3 first bit lsb");
    check(word_out == 32'h0000_0001, "R3 R5 literal odd", word_out, 32'h0000_0001);
    gap(GAPN - 2, "R6 gap after word");
    tick(0, "R6 early start ignored");
    gap(GAPN, "R6 gap ok");
    send_word(32'h0, "R5 zero ones");
    check(word_out == 32'h8000_0000, "R5 literal even", word_out, 32'h8000_0000);
    gap(GAPN - 1, "R4 gap");
    send_word(32'h8000_0003, "R5 odd with top bit");
    check(word_out == 32'h0000_0003, "R5 literal odd3", word_out, 32'h0000_0003);
    gap(GAPN - 1, "R4 gap");
    send_word(32'hC000_0000, "R5 even with top bits");
    check(word_out == 32'hC000_0000, "R5 literal even2", word_out, 32'hC000_0000);

    // R7 short word, cut at last-but-one bit
    gap(GAPN, "R7 gap");
    for (int i = 0; i < NB - 1; i++) tick(1, "R7 bits");
    tick(2, "R7 early null");
    gap(GAPN - 1, "R7 gap continues");
    // R8 overrun
    for (int i = 0; i < NB; i++) tick(i % 3 == 0, "R8 bits");
    tick(1, "R8 extra bit");
    gap(GAPN - 1, "R8 short regap");
    tick(1, "R8 data ignored");
    gap(GAPN, "R8 regap");
    // R2 illegal symbol mid-word
    for (int i = 0; i < 5; i++) tick(1, "R2 bits");
    tick(3, "R2 illegal symbol");
    gap(GAPN, "R2 gap");
    send_word(32'hA5A5_5A5A, "R2 R4 word after abort");

    for (int w = 0; w < 150; w++) begin
      int c, k;
      logic [NB-1:0] d;
      c = $urandom % 10;
      k = $urandom % NB;
      d = $urandom;
      gap(3 + $urandom % 4, "R6 random gap");
      for (int i = 0; i < NB; i++) begin
        if (c == 0 && i == k) break;
        if (c == 1 && i == k) tick(3, "R2 random illegal");
        tick(d[i] ? 1 : 0, "R3 random bits");
      end
      if (c == 2) tick($urandom % 2, "R8 random extra");
      tick(2, "R4 R7 random closing null");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule